// File: doc/BRIEF.md
# MDIO Management Register File

This block is the serial management slave of a 100 Mb/s twisted-pair PHY. It runs entirely on the management clock and samples the data line on each rising edge. It recognises a frame made of a run of preamble ones, a start pattern, a read or write opcode, a 5-bit PHY address compared against strap inputs, and a 5-bit register address. A turnaround and 16 data bits follow. The data line is modelled as a separate input, output and output enable, and the pad that merges them sits outside the block.

Two registers are implemented. The control register at address 0 holds a loopback enable and a power-down enable, which drive outputs to the PHY core. It also has a self-clearing reset bit and a speed bit that always reads 1. The status register at address 1 is read-only. It reports fixed capability bits and a link bit that latches low whenever the link-up input from the PHY core drops. The link bit keeps that 0 until a status read has completed. Every other address reads as zero, and writes to it have no effect.

Top module: `mdio_mgmt_regs`

## Requirements
- R1: After reset, `loopback`, `power_down` and `mdio_oe` are all 0.
- R2: A read of address 0 returns bit 14 = loopback, bit 11 = power-down and bit 13 = 1. Bits 15, 12 and 10..0 are 0. Writing 0 to bit 13 does not change it.
- R3: A write to address 0 with bit 15 = 0 sets `loopback` from data bit 14 and `power_down` from data bit 11. Both outputs change at the clock edge that samples the last data bit. The other written bits are ignored, and both outputs stay stable while the block drives the line.
- R4: A write to address 0 with bit 15 = 1 returns `loopback` and `power_down` to 0, whatever bits 14 and 11 hold. Bit 15 then reads back as 0.
- R5: A read of address 1 returns 16'h2000 with bit 2 set to the latched link state: bit 13 = 1, bits 14 and 0 = 0, and all other bits 0. Writes to address 1 change nothing.
- R6: The latched link bit is 0 after reset. It becomes 0 on any clock edge where `link_up` is 0 and stays 0 until a read of address 1 completes. At that point it takes the current `link_up` value.
- R7: Addresses 2 to 31 read 16'h0000, and writes to them leave both outputs and the register contents unchanged.
- R8: On a matching read, `mdio_oe` stays 0 for the first turnaround bit period. It is 1 with `mdio_out` = 0 for the second. It then stays 1 for 16 data bits sent most significant first, and returns to 0 in the bit period after the last one.
- R9: A frame whose PHY address differs from `phy_addr` is ignored: `mdio_oe` stays 0 and a write has no effect.
- R10: A frame is accepted only after at least PRE_BITS consecutive ones (default 32) followed by start bits 0 then 1. A shorter preamble causes the frame to be ignored.
- R11: Opcode 10 is a read and opcode 01 is a write, both sent MSB first. Frames with opcode 00 or 11 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| mdio_in | input | 1 | Resolved level of the management data line |
| mdio_out | output | 1 | Value driven onto the data line when enabled |
| mdio_oe | output | 1 | Drive enable for the data line |
| phy_addr | input | 5 | Strap-selected PHY address |
| link_up | input | 1 | Current link state from the PHY core |
| loopback | output | 1 | Loopback enable to the PHY core |
| power_down | output | 1 | Power-down enable to the PHY core |

## Verification
The bench builds the block with PRE_BITS = 8. This keeps each frame short enough to sweep every strap value against every frame address: 1024 reads, each checked for response or silence. Register addresses are also swept in full, and every combination of the two control bits is written and read back. The short preamble is tested at exactly one bit below the threshold and at the threshold itself, and the link latch is exercised with single-cycle drops and held drops.

// File: rtl/mdio_mgmt_regs.sv
module mdio_mgmt_regs #(
  parameter int PRE_BITS = 32
) (
  input  logic       mdc,
  input  logic       rst_n,
  input  logic       mdio_in,
  output logic       mdio_out,
  output logic       mdio_oe,
  input  logic [4:0] phy_addr,
  input  logic       link_up,
  output logic       loopback,
  output logic       power_down
);

  localparam int PCW = $clog2(PRE_BITS + 1);
  localparam logic [PCW-1:0] PRE_MAX = PCW'(PRE_BITS);

  typedef enum logic [3:0] {
    S_IDLE, S_ST, S_HDR, S_TA1, S_TA2, S_RD, S_TAW, S_WR, S_SKIP
  } st_t;

  st_t            st;
  logic [PCW-1:0] pre_cnt;
  logic [4:0]     bcnt;
  logic [10:0]    hdr;
  logic [4:0]     reg_sel;
  logic [15:0]    sh;
  logic           link_lat;
  logic [15:0]    rd_val;

  wire [11:0] hdr_w   = {hdr, mdio_in};
  wire [1:0]  op_w    = hdr_w[11:10];
  wire [4:0]  ra_w    = hdr_w[4:0];
  wire        hit     = hdr_w[9:5] == phy_addr;
  wire [15:0] wr_word = {sh[14:0], mdio_in};

  always_comb begin
    case (ra_w)
      5'd0:    rd_val = {1'b0, loopback, 1'b1, 1'b0, power_down, 11'b0};
      5'd1:    rd_val = {2'b00, 1'b1, 10'b0, link_lat, 2'b00};
      default: rd_val = 16'h0000;
    endcase
  end

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      pre_cnt    <= '0;
      bcnt       <= '0;
      hdr        <= '0;
      reg_sel    <= '0;
      sh         <= '0;
      link_lat   <= 1'b0;
      mdio_out   <= 1'b0;
      mdio_oe    <= 1'b0;
      loopback   <= 1'b0;
      power_down <= 1'b0;
    end else begin
      link_lat <= link_lat & link_up;
      case (st)
        S_IDLE: begin
          if (mdio_in) begin
            if (pre_cnt != PRE_MAX) pre_cnt <= pre_cnt + PCW'(1);
          end else begin
            if (pre_cnt == PRE_MAX) st <= S_ST;
            pre_cnt <= '0;
          end
        end
        S_ST: begin
          if (mdio_in) begin
            st   <= S_HDR;
            bcnt <= '0;
          end else begin
            st <= S_IDLE;
          end
        end
        S_HDR: begin
          hdr  <= hdr_w[10:0];
          bcnt <= bcnt + 5'd1;
          if (bcnt == 5'd11) begin
            bcnt    <= '0;
            reg_sel <= ra_w;
            if (hit && op_w == 2'b10) begin
              st <= S_TA1;
              sh <= rd_val;
            end else if (hit && op_w == 2'b01) begin
              st <= S_TAW;
            end else begin
              st <= S_SKIP;
            end
          end
        end
        S_TA1: begin
          mdio_oe  <= 1'b1;
          mdio_out <= 1'b0;
          st       <= S_TA2;
        end
        S_TA2: begin
          mdio_out <= sh[15];
          sh       <= {sh[14:0], 1'b0};
          bcnt     <= '0;
          st       <= S_RD;
        end
        S_RD: begin
          if (bcnt == 5'd15) begin
            mdio_oe  <= 1'b0;
            mdio_out <= 1'b0;
            st       <= S_IDLE;
            if (reg_sel == 5'd1) link_lat <= link_up;
          end else begin
            mdio_out <= sh[15];
            sh       <= {sh[14:0], 1'b0};
            bcnt     <= bcnt + 5'd1;
          end
        end
        S_TAW: begin
          bcnt <= bcnt + 5'd1;
          if (bcnt == 5'd1) begin
            bcnt <= '0;
            st   <= S_WR;
          end
        end
        S_WR: begin
          sh   <= wr_word;
          bcnt <= bcnt + 5'd1;
          if (bcnt == 5'd15) begin
            st <= S_IDLE;
            if (reg_sel == 5'd0) begin
              if (wr_word[15]) begin
                loopback   <= 1'b0;
                power_down <= 1'b0;
              end else begin
                loopback   <= wr_word[14];
                power_down <= wr_word[11];
              end
            end
          end
        end
        S_SKIP: begin
          bcnt <= bcnt + 5'd1;
          if (bcnt == 5'd17) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mdio_mgmt_regs_chk.sv
module mdio_mgmt_regs_chk (
  input logic mdc,
  input logic rst_n,
  input logic mdio_oe,
  input logic mdio_out,
  input logic link_up,
  input logic link_lat,
  input logic loopback,
  input logic power_down
);

  assert_reset_idle_R1: assert property (@(posedge mdc) disable iff (!rst_n)
    $rose(rst_n) |-> (!loopback && !power_down && !mdio_oe));

  assert_ta_low_R8: assert property (@(posedge mdc) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_out);

  assert_ctrl_quiet_R3: assert property (@(posedge mdc) disable iff (!rst_n)
    mdio_oe |=> ($stable(loopback) && $stable(power_down)));

  assert_link_latch_R6: assert property (@(posedge mdc) disable iff (!rst_n)
    !link_up |=> !link_lat);

endmodule

bind mdio_mgmt_regs mdio_mgmt_regs_chk u_chk (
  .mdc(mdc), .rst_n(rst_n), .mdio_oe(mdio_oe), .mdio_out(mdio_out),
  .link_up(link_up), .link_lat(link_lat), .loopback(loopback), .power_down(power_down)
);

// File: tb/mdio_mgmt_regs_test.sv
module mdio_mgmt_regs_test;
  localparam int PRE = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       host_en = 1'b1;
  logic       host_val = 1'b1;
  logic       link_up = 1'b1;
  logic [4:0] strap = 5'd9;
  logic       done = 1'b0;
  wire        mdio_out, mdio_oe, loopback, power_down;
  wire        mdio_line = mdio_oe ? mdio_out : (host_en ? host_val : 1'b1);

  mdio_mgmt_regs #(.PRE_BITS(PRE)) uut (
    .mdc(clk), .rst_n(rst_n), .mdio_in(mdio_line), .mdio_out(mdio_out),
    .mdio_oe(mdio_oe), .phy_addr(strap), .link_up(link_up),
    .loopback(loopback), .power_down(power_down)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic b);
    @(negedge clk);
    host_en  = 1'b1;
    host_val = b;
  endtask

  task automatic frame(input int pre_n, input logic [1:0] op, input logic [4:0] pa,
                       input logic [4:0] ra, input logic [15:0] wd,
                       output logic [15:0] rd, output logic any_oe, output logic ta_ok);
    logic [17:0] tail;
    tail = {2'b10, wd};
    drive(1'b0); drive(1'b0);
    for (int i = 0; i < pre_n; i++) drive(1'b1);
    drive(1'b0); drive(1'b1); drive(op[1]); drive(op[0]);
    for (int i = 4; i >= 0; i--) drive(pa[i]);
    for (int i = 4; i >= 0; i--) drive(ra[i]);
    any_oe = 1'b0; ta_ok = 1'b1; rd = '0;
    for (int i = 0; i < 18; i++) begin
      @(negedge clk);
      if (op == 2'b10) host_en = 1'b0;
      else begin host_en = 1'b1; host_val = tail[17-i]; end
      if (mdio_oe) any_oe = 1'b1;
      if (i == 0 && mdio_oe) ta_ok = 1'b0;
      if (i == 1 && !(mdio_oe && !mdio_out)) ta_ok = 1'b0;
      if (i >= 2) begin
        if (!mdio_oe) ta_ok = 1'b0;
        rd[17-i] = mdio_out;
      end
    end
    @(negedge clk);
    host_en = 1'b1; host_val = 1'b1;
    if (mdio_oe) begin ta_ok = 1'b0; any_oe = 1'b1; end
  endtask

  task automatic rd_reg(input logic [4:0] pa, input logic [4:0] ra,
                        output logic [15:0] d, output logic ok, output logic seen);
    frame(PRE, 2'b10, pa, ra, 16'h0, d, seen, ok);
  endtask

  task automatic wr_reg(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d);
    logic [15:0] x; logic a; logic b;
    frame(PRE, 2'b01, pa, ra, d, x, a, b);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d; logic ok; logic seen;
    logic [15:0] w;
    repeat (4) @(negedge clk);
    chk("R1 loopback in reset", loopback, 0);
    chk("R1 power_down in reset", power_down, 0);
    chk("R1 mdio_oe in reset", mdio_oe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 outputs after reset", {loopback, power_down, mdio_oe}, 0);

    rd_reg(9, 0, d, ok, seen);
    chk("R2 control default", d, 16'h2000);
    chk("R8 turnaround and framing", ok, 1);

    for (int k = 0; k < 8; k++) begin
      logic lb, pd, x;
      lb = k[0]; pd = k[1]; x = k[2];
      w = x ? 16'h27FF : 16'h07FF;
      w = (w & ~16'h0800) | (16'(lb) << 14) | (16'(pd) << 11);
      wr_reg(9, 0, w);
      chk("R3 loopback follows bit 14", loopback, lb);
      chk("R3 power_down follows bit 11", power_down, pd);
      rd_reg(9, 0, d, ok, seen);
      chk("R2 control readback", d, 16'h2000 | (16'(lb) << 14) | (16'(pd) << 11));
      chk("R8 read framing", ok, 1);
    end

    wr_reg(9, 0, 16'h4800);
    chk("R3 both set", {loopback, power_down}, 2'b11);
    wr_reg(9, 0, 16'hC800);
    chk("R4 reset clears controls", {loopback, power_down}, 2'b00);
    rd_reg(9, 0, d, ok, seen);
    chk("R4 reset bit self-clears", d, 16'h2000);
    wr_reg(9, 0, 16'h4000);
    wr_reg(9, 0, 16'hFFFF);
    chk("R4 reset with all ones", {loopback, power_down}, 2'b00);

    rd_reg(9, 1, d, ok, seen);
    chk("R6 link latched low from reset", d, 16'h2000);
    rd_reg(9, 1, d, ok, seen);
    chk("R5 status with link up", d, 16'h2004);
    @(negedge clk); link_up = 1'b0;
    @(negedge clk); link_up = 1'b1;
    rd_reg(9, 1, d, ok, seen);
    chk("R6 single-cycle drop latched", d, 16'h2000);
    rd_reg(9, 1, d, ok, seen);
    chk("R6 re-armed after read", d, 16'h2004);
    link_up = 1'b0;
    rd_reg(9, 1, d, ok, seen);
    chk("R6 held low read 1", d, 16'h2000);
    rd_reg(9, 1, d, ok, seen);
    chk("R6 held low read 2", d, 16'h2000);
    link_up = 1'b1;
    rd_reg(9, 1, d, ok, seen);
    chk("R6 recovered but still latched", d, 16'h2000);
    rd_reg(9, 1, d, ok, seen);
    chk("R6 recovered after read", d, 16'h2004);
    wr_reg(9, 1, 16'h0000);
    rd_reg(9, 1, d, ok, seen);
    chk("R5 status read-only", d, 16'h2004);

    for (int ra = 2; ra < 32; ra++) begin
      rd_reg(9, 5'(ra), d, ok, seen);
      chk("R7 unused address reads zero", d, 0);
    end
    wr_reg(9, 0, 16'h4800);
    for (int ra = 2; ra < 32; ra++) begin
      wr_reg(9, 5'(ra), (ra % 2 == 0) ? 16'h0000 : 16'hFFFF);
      chk("R7 unused write no effect", {loopback, power_down}, 2'b11);
    end
    rd_reg(9, 0, d, ok, seen);
    chk("R7 control intact", d, 16'h6800);

    for (int s = 0; s < 32; s++) begin
      strap = 5'(s);
      for (int pa = 0; pa < 32; pa++) begin
        rd_reg(5'(pa), 0, d, ok, seen);
        chk("R9 responds only on match", seen, (pa == s));
        if (pa == s) chk("R9 matched read data", d, 16'h6800);
      end
    end
    strap = 5'd3;
    wr_reg(4, 0, 16'h0000);
    chk("R9 foreign write ignored", {loopback, power_down}, 2'b11);

    frame(PRE - 1, 2'b10, 3, 0, 0, d, seen, ok);
    chk("R10 short preamble read ignored", seen, 0);
    frame(PRE - 1, 2'b01, 3, 0, 0, d, seen, ok);
    chk("R10 short preamble write ignored", {loopback, power_down}, 2'b11);
    frame(PRE, 2'b10, 3, 0, 0, d, seen, ok);
    chk("R10 exact preamble accepted", {ok, d}, {1'b1, 16'h6800});

    frame(PRE, 2'b00, 3, 0, 0, d, seen, ok);
    chk("R11 opcode 00 no drive", seen, 0);
    chk("R11 opcode 00 no write", {loopback, power_down}, 2'b11);
    frame(PRE, 2'b11, 3, 0, 0, d, seen, ok);
    chk("R11 opcode 11 no drive", seen, 0);
    chk("R11 opcode 11 no write", {loopback, power_down}, 2'b11);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule